// File: doc/BRIEF.md
# GPIO Pad Community Register Block

This block controls one community of general-purpose pads behind a plain 32-bit register port. Every pad owns a two-word configuration record. The first word drives the pad output and shows the sampled pad input. It also selects how the input turns into an interrupt event: level, rising edge only, or any change, with an optional inversion applied first. The second word is a free 32-bit word that software can read and write.

Each pad input passes through a two-flop synchronizer. Detected events set sticky status bits, grouped into banks of `BANK_W` pads. Software clears a status bit by writing a 1 to it. Per-bank enable words gate the status bits onto one combined interrupt line.

A read-only pointer register gives software the byte offset of the configuration array. Software uses that offset to find any pad's record, at a stride of 8 or 16 bytes.

Top module: `gpio_pad_community`

## Requirements
- R1: The word at offset 0x00C reads back `PAD_BASE` (default 0x400). Writes to that offset have no effect.
- R2: Pad n's word 0 is at `PAD_BASE + n*PAD_STRIDE` and its word 1 is 4 bytes higher (default stride 16). Word 1 keeps all 32 bits written to it. Word 0 keeps only bits 0, 23, 26:25 and 31:30 of a write, and its other bits read as 0 apart from bit 1.
- R3: Bit 0 of pad n's word 0 drives `padOut[n]`.
- R4: Bit 1 of word 0 reads the pad input after two clock edges of synchronization, without inversion. Writes to bit 1 are ignored.
- R5: In event mode 00 (level), the status bit is set on every cycle in which the effective input is 1. A set in the same cycle as a write-one-to-clear wins, so the bit stays 1.
- R6: In event mode 01, only a 0-to-1 change of the effective input sets status. The status bit rises on the third rising clock edge after the pad input changes. A held level or a falling change sets nothing.
- R7: In event mode 11, both a rising and a falling change of the effective input set status.
- R8: Event mode 10 never sets status, whatever the input does.
- R9: Bit 23 of word 0 inverts the synchronized input before event detection.
- R10: Bits 31:30 of word 0 read back exactly as last written and change only when that word is written.
- R11: The status for bank b is at 0x100+4b and the enable for bank b is at 0x120+4b. Bit i of each belongs to pad `b*BANK_W+i`. Writing a status word clears exactly the bits written as 1. Bits that have no pad read 0.
- R12: Status bits latch whether or not they are enabled. `irq` is the OR, over all pads, of status AND enable.
- R13: Read data appears on the cycle after the address is presented with `regRdEn` set, and is 0 otherwise. Unmapped or misaligned offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Byte offset for the access |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after the read strobe |
| padIn | input | NUM_PADS | Asynchronous pad inputs |
| padOut | output | NUM_PADS | Pad output drive values |
| irq | output | 1 | Combined interrupt |

## Verification
A pad input change can first be seen in the status bits, and on `irq`, after the third rising edge. Two of those edges are the synchronizer and the third is the event register. A new `rx` value appears in word 0 after two edges. Register writes take effect at the next edge, and read data is due one edge after the read strobe. The bench drives and samples only on falling edges. It waits exactly three falling edges when checking the edge-timing point, and waits at least four cycles elsewhere before comparing status, so every comparison lands after the due edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PTR,
    RD_CFG0,
    RD_CFG1,
    RD_STS,
    RD_EN
  } rdKind_e;

  typedef struct packed {
    logic        wrCfg0;
    logic        wrCfg1;
    logic        wrSts;
    logic        wrEn;
    logic        rdEn;
    rdKind_e     rdKind;
    logic [15:0] padIdx;
    logic [7:0]  bankIdx;
    logic [31:0] data;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_PADS   = 24,
  parameter int NUM_BANKS  = 2,
  parameter int PAD_STRIDE = 16,
  parameter int PAD_BASE   = 'h400
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [31:0]       regWrData,
  output ctrlStrobes_t      st
);

  localparam int STRIDE_SH = $clog2(PAD_STRIDE);
  localparam logic [ADDR_W-1:0] PTR_A   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] STS_A   = ADDR_W'(256);
  localparam logic [ADDR_W-1:0] STS_END = ADDR_W'(256 + 4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] EN_A    = ADDR_W'(288);
  localparam logic [ADDR_W-1:0] EN_END  = ADDR_W'(288 + 4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] CFG_A   = ADDR_W'(PAD_BASE);
  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(PAD_BASE + NUM_PADS * PAD_STRIDE);

  rdKind_e           kind;
  logic [15:0]       padIdx;
  logic [7:0]        bankIdx;
  logic [ADDR_W-1:0] off;

  // Address decode: one target at most, misaligned offsets hit nothing
  always_comb begin
    kind    = RD_NONE;
    padIdx  = '0;
    bankIdx = '0;
    off     = regAddr - CFG_A;
    if (regAddr[1:0] == 2'b00) begin
      if (regAddr == PTR_A) begin
        kind = RD_PTR;
      end else if (regAddr >= STS_A && regAddr < STS_END) begin
        kind    = RD_STS;
        bankIdx = 8'((regAddr - STS_A) >> 2);
      end else if (regAddr >= EN_A && regAddr < EN_END) begin
        kind    = RD_EN;
        bankIdx = 8'((regAddr - EN_A) >> 2);
      end else if (regAddr >= CFG_A && regAddr < CFG_END) begin
        padIdx = 16'(off >> STRIDE_SH);
        if (off[STRIDE_SH-1:0] == STRIDE_SH'(0)) begin
          kind = RD_CFG0;
        end else if (off[STRIDE_SH-1:0] == STRIDE_SH'(4)) begin
          kind = RD_CFG1;
        end
      end
    end
  end

  always_comb begin
    st.wrCfg0  = regWrEn && (kind == RD_CFG0);
    st.wrCfg1  = regWrEn && (kind == RD_CFG1);
    st.wrSts   = regWrEn && (kind == RD_STS);
    st.wrEn    = regWrEn && (kind == RD_EN);
    st.rdEn    = regRdEn;
    st.rdKind  = kind;
    st.padIdx  = padIdx;
    st.bankIdx = bankIdx;
    st.data    = regWrData;
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PADS = 24,
  parameter int BANK_W   = 16,
  parameter int PAD_BASE = 'h400
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        st,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic [31:0]         rdData,
  output logic                irq
);

  localparam logic [31:0] PTR_VAL = 32'(PAD_BASE);

  logic [NUM_PADS-1:0] sync1, sync2;
  logic [NUM_PADS-1:0] hitPad, hitBank, evtSet, stsClr, irqPart;
  logic        txBit   [NUM_PADS];
  logic        invBit  [NUM_PADS];
  logic        prevEff [NUM_PADS];
  logic        sts     [NUM_PADS];
  logic        en      [NUM_PADS];
  logic [1:0]  mode    [NUM_PADS];
  logic [1:0]  rstCfg  [NUM_PADS];
  logic [31:0] word1   [NUM_PADS];
  logic [31:0] cfg0Part[NUM_PADS];
  logic [31:0] cfg1Part[NUM_PADS];
  logic [31:0] stsPart [NUM_PADS];
  logic [31:0] enPart  [NUM_PADS];
  logic [31:0] rdNext;

  // Two-flop input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= padIn;
      sync2 <= sync1;
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int BANK = p / BANK_W;
    localparam int BIT  = p % BANK_W;
    logic eff;
    logic evt;

    assign hitPad[p]  = (st.padIdx == 16'(p));
    assign hitBank[p] = (st.bankIdx == 8'(BANK));
    assign eff        = sync2[p] ^ invBit[p];

    always_comb begin
      case (mode[p])
        2'b00:   evt = eff;
        2'b01:   evt = eff & ~prevEff[p];
        2'b11:   evt = eff ^ prevEff[p];
        default: evt = 1'b0;
      endcase
    end

    assign evtSet[p]  = evt;
    assign stsClr[p]  = st.wrSts & hitBank[p] & st.data[BIT];
    assign irqPart[p] = sts[p] & en[p];
    assign padOut[p]  = txBit[p];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txBit[p]   <= 1'b0;
        invBit[p]  <= 1'b0;
        mode[p]    <= 2'b00;
        rstCfg[p]  <= 2'b00;
        word1[p]   <= '0;
        en[p]      <= 1'b0;
        prevEff[p] <= 1'b0;
        sts[p]     <= 1'b0;
      end else begin
        if (st.wrCfg0 && hitPad[p]) begin
          txBit[p]  <= st.data[0];
          invBit[p] <= st.data[23];
          mode[p]   <= st.data[26:25];
          rstCfg[p] <= st.data[31:30];
        end
        if (st.wrCfg1 && hitPad[p]) word1[p] <= st.data;
        if (st.wrEn && hitBank[p])  en[p]    <= st.data[BIT];
        prevEff[p] <= eff;
        // set has priority over write-one-to-clear
        sts[p] <= (sts[p] & ~stsClr[p]) | evtSet[p];
      end
    end

    assign cfg0Part[p] = hitPad[p] ?
      {rstCfg[p], 3'b000, mode[p], 1'b0, invBit[p], 21'd0, sync2[p], txBit[p]} : '0;
    assign cfg1Part[p] = hitPad[p] ? word1[p] : '0;
    assign stsPart[p]  = (hitBank[p] && sts[p]) ? (32'd1 << BIT) : '0;
    assign enPart[p]   = (hitBank[p] && en[p])  ? (32'd1 << BIT) : '0;

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      (stsClr[p] && !evtSet[p]) |=> !sts[p]); // R11
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (sts[p] && !stsClr[p]) |=> sts[p]); // R12
    AST_RST_FIELD_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      !(st.wrCfg0 && hitPad[p]) |=> $stable(rstCfg[p])); // R10
    AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (mode[p] == 2'b10 && !sts[p]) |=> !sts[p]); // R8
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      (mode[p] == 2'b01 && evtSet[p]) |=> (mode[p] != 2'b01 || !evtSet[p])); // R6
  end

  always_comb begin
    rdNext = '0;
    case (st.rdKind)
      RD_PTR:  rdNext = PTR_VAL;
      RD_CFG0: for (int p = 0; p < NUM_PADS; p++) rdNext = rdNext | cfg0Part[p];
      RD_CFG1: for (int p = 0; p < NUM_PADS; p++) rdNext = rdNext | cfg1Part[p];
      RD_STS:  for (int p = 0; p < NUM_PADS; p++) rdNext = rdNext | stsPart[p];
      RD_EN:   for (int p = 0; p < NUM_PADS; p++) rdNext = rdNext | enPart[p];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= st.rdEn ? rdNext : '0;
  end

  assign irq = |irqPart;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdEn && st.rdKind == RD_NONE) |=> (rdData == '0)); // R13

endmodule

// File: rtl/gpio_pad_community.sv
module gpio_pad_community
  import gpio_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_PADS   = 24,
  parameter int BANK_W     = 16,
  parameter int PAD_STRIDE = 16,
  parameter int PAD_BASE   = 'h400
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  input  logic [NUM_PADS-1:0] padIn,
  output logic [NUM_PADS-1:0] padOut,
  output logic                irq
);

  localparam int NUM_BANKS = (NUM_PADS + BANK_W - 1) / BANK_W;

  ctrlStrobes_t st;

  gpio_ctrl #(
    .ADDR_W(ADDR_W), .NUM_PADS(NUM_PADS), .NUM_BANKS(NUM_BANKS),
    .PAD_STRIDE(PAD_STRIDE), .PAD_BASE(PAD_BASE)
  ) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .st(st)
  );

  gpio_datapath #(
    .NUM_PADS(NUM_PADS), .BANK_W(BANK_W), .PAD_BASE(PAD_BASE)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .st(st), .padIn(padIn),
    .padOut(padOut), .rdData(regRdData), .irq(irq)
  );

endmodule

// File: tb/test_gpio_pad_community.sv
module test_gpio_pad_community;

  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rstN;
  logic [11:0]   regAddr;
  logic          regWrEn, regRdEn;
  logic [31:0]   regWrData, regRdData;
  logic [NP-1:0] padIn, padOut;
  logic          irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_pad_community i_gpio_pad_community (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .padIn(padIn), .padOut(padOut), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cfgAddr(int p, int w);
    return 12'(32'h400 + p * 16 + w * 4);
  endfunction

  function automatic logic [31:0] expW0(logic [31:0] v, logic rx);
    return (v & 32'hC680_0001) | {30'd0, rx, 1'b0};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [11:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] r, v0, v1;
    int p;
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regRdEn = 1'b0;
    regWrData = '0; padIn = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    check("R12 irq after reset", 32'(irq), 0);
    check("R3 padOut after reset", 32'(padOut), 0);
    regRead(12'h100, r); check("R11 status reset", r, 0);
    regRead(12'h120, r); check("R11 enable reset", r, 0);
    regRead(cfgAddr(0, 0), r); check("R2 word0 reset", r, 0);
    regRead(12'h00C, r); check("R1 pointer", r, 32'h400);
    regWrite(12'h00C, 32'hFFFF_FFFF);
    regRead(12'h00C, r); check("R1 pointer read-only", r, 32'h400);

    // random configuration traffic
    padIn = NP'($urandom());
    idle(3);
    for (int k = 0; k < 16; k++) begin
      p  = $urandom_range(NP - 1);
      v1 = $urandom();
      v0 = $urandom();
      regWrite(cfgAddr(p, 1), v1);
      regRead(cfgAddr(p, 1), r); check("R2 word1 readback", r, v1);
      regWrite(cfgAddr(p, 0), v0);
      regRead(cfgAddr(p, 0), r);
      check("R2 word0 readback", r, expW0(v0, padIn[p]));
      check("R10 reset field", 32'(r[31:30]), 32'(v0[31:30]));
      check("R3 padOut drive", 32'(padOut[p]), 32'(v0[0]));
    end

    // all pads to event mode 10, then no event under input changes
    for (int q = 0; q < NP; q++) regWrite(cfgAddr(q, 0), 32'h0400_0000);
    regWrite(12'h100, 32'hFFFF_FFFF);
    regWrite(12'h104, 32'hFFFF_FFFF);
    padIn = ~padIn;
    idle(4);
    regRead(12'h100, r); check("R8 mode 10 bank0 quiet", r, 0);
    regRead(12'h104, r); check("R8 mode 10 bank1 quiet", r, 0);
    regRead(cfgAddr(7, 0), r);
    check("R4 rx sampled", r, 32'h0400_0000 | {30'd0, padIn[7], 1'b0});

    // level mode on pad 3, set wins over clear
    padIn[3] = 1'b1;
    idle(3);
    regWrite(cfgAddr(3, 0), 32'h0);
    idle(2);
    regRead(12'h100, r); check("R5 level sets status", r, 32'h8);
    regWrite(12'h100, 32'h8);
    regRead(12'h100, r); check("R5 set beats clear", r, 32'h8);
    padIn[3] = 1'b0;
    idle(4);
    regWrite(12'h100, 32'h8);
    regRead(12'h100, r); check("R11 write-one clears", r, 0);
    regWrite(cfgAddr(3, 0), 32'h0400_0000);

    // single rising edge on pad 5 with exact timing
    padIn[5] = 1'b0;
    regWrite(cfgAddr(5, 0), 32'h0200_0000);
    idle(4);
    regWrite(12'h100, 32'hFFFF_FFFF);
    regWrite(12'h120, 32'h20);
    check("R12 irq idle", 32'(irq), 0);
    padIn[5] = 1'b1;
    @(negedge clk); check("R6 edge not yet (1)", 32'(irq), 0);
    @(negedge clk); check("R6 edge not yet (2)", 32'(irq), 0);
    @(negedge clk); check("R6 edge on third edge", 32'(irq), 1);
    regRead(12'h100, r); check("R6 edge status bit", r, 32'h20);
    regWrite(12'h100, 32'h20);
    check("R12 irq drops after clear", 32'(irq), 0);
    idle(2);
    regRead(12'h100, r); check("R6 held level no event", r, 0);
    padIn[5] = 1'b0;
    idle(4);
    regRead(12'h100, r); check("R6 falling ignored", r, 0);

    // both edges
    regWrite(cfgAddr(5, 0), 32'h0600_0000);
    idle(2);
    regWrite(12'h100, 32'hFFFF_FFFF);
    padIn[5] = 1'b1;
    idle(4);
    regRead(12'h100, r); check("R7 rising sets", r, 32'h20);
    regWrite(12'h100, 32'h20);
    padIn[5] = 1'b0;
    idle(4);
    regRead(12'h100, r); check("R7 falling sets", r, 32'h20);
    regWrite(12'h100, 32'h20);
    regWrite(12'h120, 32'h0);
    regWrite(cfgAddr(5, 0), 32'h0400_0000);

    // inverted input on pad 17 (bank 1 bit 1)
    padIn[17] = 1'b1;
    idle(3);
    regWrite(cfgAddr(17, 0), 32'h0280_0000);
    idle(3);
    regWrite(12'h104, 32'hFFFF_FFFF);
    regRead(12'h104, r); check("R9 inverted high no event", r, 0);
    padIn[17] = 1'b0;
    idle(4);
    regRead(12'h104, r); check("R9 inverted fall is rising", r, 32'h2);
    regRead(cfgAddr(17, 0), r); check("R4 rx not inverted", r, 32'h0280_0000);

    // status independent of enable, irq gating
    check("R12 latched but disabled", 32'(irq), 0);
    regWrite(12'h124, 32'h2);
    check("R12 enabled raises irq", 32'(irq), 1);
    regWrite(12'h124, 32'h0);
    check("R12 disabled drops irq", 32'(irq), 0);
    regRead(12'h104, r); check("R12 status kept", r, 32'h2);

    // partial bank and unmapped space
    regWrite(12'h124, 32'hFFFF_FFFF);
    regRead(12'h124, r); check("R11 partial bank bits", r, 32'h0000_00FF);
    regWrite(12'h124, 32'h0);
    regRead(12'h408, r); check("R13 hole in pad record", r, 0);
    regRead(12'h200, r); check("R13 unmapped offset", r, 0);
    regRead(12'h108, r); check("R13 missing bank", r, 0);
    regRead(12'h402, r); check("R13 misaligned", r, 0);
    regRead(12'h00C, r);
    @(negedge clk);
    check("R13 data only after strobe", regRdData, 0);

    done = 1'b1;
    summary();
  end

endmodule